// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block generates data-memory addresses for a load/store path. It holds four buffer contexts. Each context has a pointer, a buffer base, a buffer length and a signed step. A request picks a context, a stepping mode, pre- or post-modify and an access size. One cycle later the block returns the effective address, together with a flag that shows whether the address is misaligned for that size.

Three stepping modes are provided:

- **Linear:** plain addition.
- **Circular:** modulo wrap inside `[base, base+length)`, with no alignment limit on where the buffer sits.
- **Bit-reversed:** the step is added with the carry running from the top bit downward, which gives FFT-style reordering.

Software loads the context registers through a write port, one field per write.

Top module: `circ_agu`

## Requirements
- R1: `addr_o` and `misalign_o` are registered. They show the result of a request one clock edge after `req_i` is sampled high. `valid_o` is high in exactly the cycle after a sampled request and low otherwise, and `misalign_o` is 0 when `valid_o` is 0.
- R2: There are four contexts, written through `wr_*`. The field codes are 0 pointer, 1 base, 2 length and 3 step. Reset clears every field of every context to 0, so a post-modify request after reset returns address 0.
- R3: Post-modify (`req_pre_i`=0) returns the current pointer as the address, and then stores the stepped pointer into the context.
- R4: Pre-modify (`req_pre_i`=1) returns the stepped pointer as the address and leaves the stored pointer unchanged.
- R5: In linear mode (code 0, and the spare code 3), the stepped pointer is pointer + step, modulo 2^32.
- R6: In circular mode (code 1), a stepped pointer at or past base+length has length subtracted from it. This holds for any base, aligned or not.
- R7: In circular mode, a stepped pointer below base has length added to it.
- R8: In bit-reverse mode (code 2), the step is added with the carry running from bit 31 toward bit 0, and a carry out of bit 0 is dropped. For example, from pointer 0 with step 4, the sequence is 0,4,2,6,1,5,3,7,0.
- R9: The size codes are 0 single, 1 dual, 2 quad, and 3 (handled as quad). `misalign_o` is set when a dual address is odd or when a quad address is not a multiple of 4. A single access never sets it.
- R10: A request reads the context values from before any write in the same cycle. A pointer write to the same context in that cycle overrides the post-modify update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Context field write strobe |
| wr_ctx_i | input | 2 | Context to write |
| wr_sel_i | input | 2 | Field code (0 pointer, 1 base, 2 length, 3 step) |
| wr_data_i | input | 32 | Write data |
| req_i | input | 1 | Address request |
| req_ctx_i | input | 2 | Context used by the request |
| req_pre_i | input | 1 | 1 pre-modify, 0 post-modify |
| req_mode_i | input | 2 | 0 linear, 1 circular, 2 bit-reverse, 3 linear |
| req_size_i | input | 2 | 0 single, 1 dual, 2 quad, 3 quad |
| addr_o | output | 32 | Effective address |
| valid_o | output | 1 | Address valid |
| misalign_o | output | 1 | Address misaligned for its size |

## Verification
Every result is due exactly one edge after its request. The bench drives each request on a falling edge and reads `addr_o`, `valid_o` and `misalign_o` on the next falling edge. Requests are issued back to back, so the pointer update from one request must already be in place for the next request to the same context, with no idle cycle between them. Register writes take one edge to land, and the bench checks their effect through the next request's address.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;
  typedef enum logic [1:0] {MODE_LIN = 2'd0, MODE_CIRC = 2'd1, MODE_BREV = 2'd2, MODE_LIN_ALT = 2'd3} step_mode_e;
  typedef enum logic [1:0] {SZ_ONE = 2'd0, SZ_TWO = 2'd1, SZ_FOUR = 2'd2, SZ_FOUR_ALT = 2'd3} acc_size_e;
  typedef enum logic [1:0] {FLD_PTR = 2'd0, FLD_BASE = 2'd1, FLD_LEN = 2'd2, FLD_STEP = 2'd3} ctx_field_e;
endpackage

// File: rtl/circ_agu_ctx_regs.sv
module circ_agu_ctx_regs
  import circ_agu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NCTX = 4,
  localparam int CW  = $clog2(NCTX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_ctx_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [CW-1:0] upd_ctx_i,
  input  logic [AW-1:0] upd_ptr_i,
  input  logic [CW-1:0] rd_ctx_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] len_o,
  output logic [AW-1:0] step_o
);
  logic [AW-1:0] ptr_q  [NCTX];
  logic [AW-1:0] base_q [NCTX];
  logic [AW-1:0] len_q  [NCTX];
  logic [AW-1:0] step_q [NCTX];

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    logic hit_w;
    assign hit_w = wr_en_i && (wr_ctx_i == CW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[g]  <= '0;
        base_q[g] <= '0;
        len_q[g]  <= '0;
        step_q[g] <= '0;
      end else begin
        // software write to the pointer wins over the request update
        if (hit_w && wr_sel_i == FLD_PTR)                ptr_q[g] <= wr_data_i;
        else if (upd_en_i && upd_ctx_i == CW'(g))        ptr_q[g] <= upd_ptr_i;
        if (hit_w && wr_sel_i == FLD_BASE)               base_q[g] <= wr_data_i;
        if (hit_w && wr_sel_i == FLD_LEN)                len_q[g]  <= wr_data_i;
        if (hit_w && wr_sel_i == FLD_STEP)               step_q[g] <= wr_data_i;
      end
    end
  end

  assign ptr_o  = ptr_q[rd_ctx_i];
  assign base_o = base_q[rd_ctx_i];
  assign len_o  = len_q[rd_ctx_i];
  assign step_o = step_q[rd_ctx_i];
endmodule

// File: rtl/circ_agu_step.sv
module circ_agu_step
  import circ_agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] step_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] nxt_o
);
  localparam int XW = AW + 2;

  // bit-reverse stepping: reverse, add, reverse back
  logic [AW-1:0] rptr, rstep, rsum, brev;
  for (genvar k = 0; k < AW; k++) begin : g_rev
    assign rptr[k]  = ptr_i[AW-1-k];
    assign rstep[k] = step_i[AW-1-k];
    assign brev[k]  = rsum[AW-1-k];
  end
  assign rsum = rptr + rstep;

  // circular stepping on the offset from base, wrap by one length
  logic [AW-1:0]        off;
  logic signed [XW-1:0] raw, wrapped;
  assign off = ptr_i - base_i;
  assign raw = $signed({2'b00, off}) + $signed({{2{step_i[AW-1]}}, step_i});

  always_comb begin
    if (raw < 0)                              wrapped = raw + $signed({2'b00, len_i});
    else if (raw >= $signed({2'b00, len_i}))  wrapped = raw - $signed({2'b00, len_i});
    else                                      wrapped = raw;
  end

  always_comb begin
    unique case (step_mode_e'(mode_i))
      MODE_CIRC: nxt_o = base_i + wrapped[AW-1:0];
      MODE_BREV: nxt_o = brev;
      default:   nxt_o = ptr_i + step_i;
    endcase
  end
endmodule

// File: rtl/circ_agu.sv
module circ_agu
  import circ_agu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NCTX = 4,
  localparam int CW  = $clog2(NCTX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_ctx_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          req_i,
  input  logic [CW-1:0] req_ctx_i,
  input  logic          req_pre_i,
  input  logic [1:0]    req_mode_i,
  input  logic [1:0]    req_size_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          misalign_o
);
  logic [AW-1:0] ptr, base, len, step, nxt, eff;
  logic          mis;

  circ_agu_ctx_regs #(.AW(AW), .NCTX(NCTX)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_ctx_i  (wr_ctx_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .upd_en_i  (req_i && !req_pre_i),
    .upd_ctx_i (req_ctx_i),
    .upd_ptr_i (nxt),
    .rd_ctx_i  (req_ctx_i),
    .ptr_o     (ptr),
    .base_o    (base),
    .len_o     (len),
    .step_o    (step)
  );

  circ_agu_step #(.AW(AW)) u_step (
    .ptr_i  (ptr),
    .base_i (base),
    .len_i  (len),
    .step_i (step),
    .mode_i (req_mode_i),
    .nxt_o  (nxt)
  );

  assign eff = req_pre_i ? nxt : ptr;

  always_comb begin
    unique case (acc_size_e'(req_size_i))
      SZ_ONE:  mis = 1'b0;
      SZ_TWO:  mis = eff[0];
      default: mis = |eff[1:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      valid_o    <= 1'b0;
      misalign_o <= 1'b0;
    end else begin
      valid_o    <= req_i;
      misalign_o <= req_i && mis;
      if (req_i) addr_o <= eff;
    end
  end
endmodule

// File: rtl/circ_agu_chk.sv
module circ_agu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [1:0] req_size_i,
  input logic       valid_o,
  input logic       misalign_o,
  input logic [1:0] addr_lo
);
  a_r1_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  a_r1_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !misalign_o));
  a_r9_single_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_size_i == 2'd0) |=> !misalign_o);
  a_r9_dual_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_size_i == 2'd1) |=> (misalign_o == addr_lo[0]));
  a_r9_quad_mod4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_size_i[1]) |=> (misalign_o == (|addr_lo)));
endmodule

bind circ_agu circ_agu_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .req_size_i (req_size_i),
  .valid_o    (valid_o),
  .misalign_o (misalign_o),
  .addr_lo    (addr_o[1:0])
);

// File: tb/circ_agu_tb.sv
`timescale 1ns/1ps
module circ_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ctx = '0, wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        req = 1'b0, pre = 1'b0;
  logic [1:0]  ctx = '0, mode = '0, size = '0;
  logic [31:0] addr;
  logic        valid, mis;
  int          total = 0, fails = 0;

  always #4 clk = ~clk;

  circ_agu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ctx_i(wr_ctx),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .req_i(req), .req_ctx_i(ctx),
    .req_pre_i(pre), .req_mode_i(mode), .req_size_i(size),
    .addr_o(addr), .valid_o(valid), .misalign_o(mis)
  );

  typedef struct packed {
    logic [1:0]  c;
    logic        p;
    logic [1:0]  m;
    logic [1:0]  s;
    logic [31:0] a;
    logic        x;
  } vec_t;

  // ctx, pre, mode, size, expected addr, expected misalign
  localparam vec_t VEC [28] = '{
    '{2'd0, 1'b0, 2'd1, 2'd0, 32'd100, 1'b0},  // R3 R6
    '{2'd0, 1'b0, 2'd1, 2'd0, 32'd103, 1'b0},
    '{2'd0, 1'b0, 2'd1, 2'd0, 32'd106, 1'b0},
    '{2'd0, 1'b0, 2'd1, 2'd0, 32'd109, 1'b0},
    '{2'd0, 1'b0, 2'd1, 2'd0, 32'd102, 1'b0},  // R6 wrap past top
    '{2'd1, 1'b0, 2'd1, 2'd1, 32'd8,   1'b0},  // R7
    '{2'd1, 1'b0, 2'd1, 2'd1, 32'd11,  1'b1},  // R7 wrap below base, R9 odd dual
    '{2'd1, 1'b0, 2'd1, 2'd0, 32'd9,   1'b0},
    '{2'd1, 1'b0, 2'd1, 2'd0, 32'd7,   1'b0},
    '{2'd1, 1'b0, 2'd1, 2'd0, 32'd10,  1'b0},  // R7
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd0,   1'b0},  // R8
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd4,   1'b0},
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd2,   1'b0},
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd6,   1'b0},
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd1,   1'b0},
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd5,   1'b0},
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd3,   1'b0},
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd7,   1'b0},
    '{2'd2, 1'b0, 2'd2, 2'd0, 32'd0,   1'b0},  // R8 carry out dropped
    '{2'd3, 1'b1, 2'd0, 2'd2, 32'd20,  1'b0},  // R4 R5
    '{2'd3, 1'b1, 2'd0, 2'd2, 32'd20,  1'b0},  // R4 pointer kept
    '{2'd3, 1'b0, 2'd0, 2'd2, 32'd16,  1'b0},  // R3
    '{2'd3, 1'b1, 2'd3, 2'd2, 32'd24,  1'b0},  // R5 spare code
    '{2'd3, 1'b0, 2'd0, 2'd1, 32'd20,  1'b0},
    '{2'd0, 1'b1, 2'd1, 2'd0, 32'd108, 1'b0},  // R4 circular
    '{2'd0, 1'b1, 2'd1, 2'd2, 32'd108, 1'b0},  // R9 quad aligned
    '{2'd1, 1'b1, 2'd1, 2'd0, 32'd11,  1'b0},  // R4 R7
    '{2'd1, 1'b1, 2'd1, 2'd3, 32'd11,  1'b1}   // R9 code 3 as quad
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] c, input logic [1:0] f, input logic [31:0] d);
    wr_en = 1'b1; wr_ctx = c; wr_sel = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rq(input logic [1:0] c, input logic p, input logic [1:0] m, input logic [1:0] s);
    req = 1'b1; ctx = c; pre = p; mode = m; size = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL R1 watchdog expired got=hang exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset valid", {31'd0, valid}, 32'd0);
    chk("R1 reset addr", addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset contents: post-modify linear gives 0
    rq(2'd0, 1'b0, 2'd0, 2'd0);
    chk("R2 reset pointer", addr, 32'd0);
    chk("R1 valid after req", {31'd0, valid}, 32'd1);
    @(negedge clk);
    chk("R1 idle valid", {31'd0, valid}, 32'd0);
    chk("R1 idle misalign", {31'd0, mis}, 32'd0);

    wr(2'd0, 2'd1, 32'd100); wr(2'd0, 2'd2, 32'd10); wr(2'd0, 2'd3, 32'd3);  wr(2'd0, 2'd0, 32'd100);
    wr(2'd1, 2'd1, 32'd7);   wr(2'd1, 2'd2, 32'd5);  wr(2'd1, 2'd3, -32'sd2); wr(2'd1, 2'd0, 32'd8);
    wr(2'd2, 2'd3, 32'd4);   wr(2'd2, 2'd0, 32'd0);
    wr(2'd3, 2'd3, 32'd4);   wr(2'd3, 2'd0, 32'd16);

    for (int i = 0; i < 28; i++) begin
      req = 1'b1; ctx = VEC[i].c; pre = VEC[i].p; mode = VEC[i].m; size = VEC[i].s;
      @(negedge clk);
      chk($sformatf("R3-table %0d addr", i), addr, VEC[i].a);
      chk($sformatf("R9 table %0d misalign", i), {31'd0, mis}, {31'd0, VEC[i].x});
    end
    req = 1'b0;
    @(negedge clk);

    // R10: same-cycle pointer write and post request on ctx 3 (pointer 24, step 4)
    wr_en = 1'b1; wr_ctx = 2'd3; wr_sel = 2'd0; wr_data = 32'd200;
    req = 1'b1; ctx = 2'd3; pre = 1'b0; mode = 2'd0; size = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; req = 1'b0;
    chk("R10 old pointer used", addr, 32'd24);
    rq(2'd3, 1'b0, 2'd0, 2'd0);
    chk("R10 write wins", addr, 32'd200);

    // R5: linear wrap modulo 2^32
    wr(2'd3, 2'd0, 32'hFFFF_FFFE);
    rq(2'd3, 1'b1, 2'd0, 2'd1);
    chk("R5 linear wrap", addr, 32'd2);
    chk("R9 dual even", {31'd0, mis}, 32'd0);

    // R9: quad misaligned on linear post-modify
    wr(2'd3, 2'd0, 32'd6);
    rq(2'd3, 1'b0, 2'd0, 2'd2);
    chk("R9 quad misaligned", {31'd0, mis}, 32'd1);

    // R2: reset clears contexts
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rq(2'd1, 1'b0, 2'd1, 2'd0);
    chk("R2 cleared after reset", addr, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule